// File: doc/BRIEF.md
# Local-to-Host Address Window Translator

This block sits between a local processor and a host bus bridge. The local processor can only issue memory cycles. The translator compares each local address against two programmable windows. A hit in the memory window becomes a host memory access at a remapped address. A hit in the I/O window becomes either a host I/O access or a host configuration access, depending on an enable bit in the configuration word.

Both windows share one range mask. A `1` in the mask marks an address bit that takes part in the window comparison, and that bit is replaced by the remap base on memory translation. A `0` bit is passed through as the offset inside the window.

Registers are written through a simple select/data write port. Each access is presented for one cycle. Its result (hit, cycle kind, host address) is registered and appears on the outputs in the following cycle. Issuing the host cycle, buffering and bus timing belong to other blocks.

Top module: `winxlate_top`

## Requirements
- R1: After reset every register is zero and both windows are disabled, so the outputs are `outHit`=0, `outType`=0 and `outAddr`=0, and no access hits until the block is programmed.
- R2: Register selects are 0 range mask, 1 memory base, 2 I/O base, 3 remap base, 4 configuration word and 5 window enables (bit 0 memory, bit 1 I/O). An access with `accValid`=1 whose masked address equals the masked memory base, while the memory window is enabled, gives `outHit`=1 and `outType`=1 (memory) in the next cycle.
- R3: The memory translated address is `(accAddr & ~mask) | (remapBase & mask)`.
- R4: An I/O-window hit while configuration-word bit 31 is 0 gives `outType`=2 (I/O), with `outAddr = accAddr & ~mask`.
- R5: An I/O-window hit while configuration-word bit 31 is 1 gives `outType`=3 (configuration). `outAddr` is the configuration word with bits 31:24 and 1:0 cleared, keeping the bus [23:16], device [15:11], function [10:8] and register [7:2] fields.
- R6: When both windows match the same address, the memory window wins.
- R7: With `accValid`=0, or with no window matching, the next-cycle outputs are `outHit`=0, `outType`=0 (none) and `outAddr`=0.
- R8: Only address bits set in the range mask are compared. Addresses that differ from a base only in unmasked bits still hit.
- R9: A register write takes effect for accesses presented from the following cycle on. An access presented in the same cycle as the write uses the old value.
- R10: A window whose enable bit is 0 never hits, whatever its base.
- R11: Writes with selects 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 3 | Register select |
| regWdata | input | 32 | Register write data |
| accValid | input | 1 | Local access present this cycle |
| accAddr | input | 32 | Local access address |
| outHit | output | 1 | A window matched the previous cycle's access |
| outType | output | 2 | 0 none, 1 memory, 2 I/O, 3 configuration |
| outAddr | output | 32 | Translated host address |

## Verification
On every cycle, the checker verifies the following:
- the hit flag agrees with the cycle kind;
- a miss leaves a zero address;
- an idle input yields no hit in the next cycle;
- memory and I/O results keep the unmasked offset bits of the previous access;
- configuration results appear only when the enable bit was set.

Window priority, remap arithmetic, configuration field packing, write timing against a concurrent access, ignored selects and disabled windows can only be shown by the bench's scenarios, which compare against a behavioural model.

// File: rtl/winxlate_pkg.sv
package winxlate_pkg;

  typedef enum logic [1:0] {
    CYC_NONE = 2'd0,
    CYC_MEM  = 2'd1,
    CYC_IO   = 2'd2,
    CYC_CFG  = 2'd3
  } cycKind_t;

  // Strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic selMem;
    logic selIo;
    logic selCfg;
  } xlStrobe_t;

  localparam int NUM_WIN = 2;
  localparam int WIN_MEM = 0;
  localparam int WIN_IO  = 1;

  localparam int SEL_MASK  = 0;
  localparam int SEL_MBASE = 1;
  localparam int SEL_IBASE = 2;
  localparam int SEL_REMAP = 3;
  localparam int SEL_CFG   = 4;
  localparam int SEL_WEN   = 5;

endpackage

// File: rtl/winxlate_match.sv
module winxlate_match #(
  parameter int ADDR_W = 32
) (
  input  logic              winEnable,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  output logic              hit
);
  logic [ADDR_W-1:0] diffBits;

  assign diffBits = (addr ^ base) & mask;
  assign hit      = winEnable && (diffBits == '0);
endmodule

// File: rtl/winxlate_ctrl.sv
module winxlate_ctrl
  import winxlate_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SEL_W      = 3,
  parameter int CFG_EN_BIT = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWe,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [ADDR_W-1:0] regWdata,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  output logic [ADDR_W-1:0] rangeMask,
  output logic [ADDR_W-1:0] remapBase,
  output logic [ADDR_W-1:0] cfgWord,
  output logic              cfgEnable,
  output xlStrobe_t         strobe
);
  logic [ADDR_W-1:0] winBase [NUM_WIN];
  logic [NUM_WIN-1:0] winEn;
  logic [NUM_WIN-1:0] winHit;

  // Register file: writes land at the edge, so same-cycle accesses see old values
  always_ff @(posedge clk) begin
    if (rst) begin
      rangeMask <= '0;
      remapBase <= '0;
      cfgWord   <= '0;
      winEn     <= '0;
      for (int w = 0; w < NUM_WIN; w++) winBase[w] <= '0;
    end else if (regWe) begin
      case (int'(regSel))
        SEL_MASK:  rangeMask        <= regWdata;
        SEL_MBASE: winBase[WIN_MEM] <= regWdata;
        SEL_IBASE: winBase[WIN_IO]  <= regWdata;
        SEL_REMAP: remapBase        <= regWdata;
        SEL_CFG:   cfgWord          <= regWdata;
        SEL_WEN:   winEn            <= regWdata[NUM_WIN-1:0];
        default:   ;
      endcase
    end
  end

  assign cfgEnable = cfgWord[CFG_EN_BIT];

  for (genvar w = 0; w < NUM_WIN; w++) begin : gWin
    winxlate_match #(.ADDR_W(ADDR_W)) u_match (
      .winEnable(winEn[w]),
      .addr     (accAddr),
      .base     (winBase[w]),
      .mask     (rangeMask),
      .hit      (winHit[w])
    );
  end

  // Memory window takes priority over the I/O window
  always_comb begin
    strobe        = '0;
    if (accValid) begin
      if (winHit[WIN_MEM]) begin
        strobe.selMem = 1'b1;
      end else if (winHit[WIN_IO]) begin
        strobe.selCfg = cfgEnable;
        strobe.selIo  = !cfgEnable;
      end
    end
  end
endmodule

// File: rtl/winxlate_dp.sv
module winxlate_dp
  import winxlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 8,
  parameter int DEV_W  = 5,
  parameter int FN_W   = 3,
  parameter int REG_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  xlStrobe_t         strobe,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [ADDR_W-1:0] rangeMask,
  input  logic [ADDR_W-1:0] remapBase,
  input  logic [ADDR_W-1:0] cfgWord,
  output logic              outHit,
  output cycKind_t          outKind,
  output logic [ADDR_W-1:0] outAddr
);
  localparam int FIELD_LO = 2;
  localparam int FIELD_HI = FIELD_LO + REG_W + FN_W + DEV_W + BUS_W;
  localparam logic [63:0] FIELD_MASK64 = ((64'd1 << FIELD_HI) - 64'd1) & ~64'd3;
  localparam logic [ADDR_W-1:0] FIELD_MASK = FIELD_MASK64[ADDR_W-1:0];

  logic [ADDR_W-1:0] offsetBits;
  logic [ADDR_W-1:0] memAddr;
  logic [ADDR_W-1:0] cfgAddr;
  logic [ADDR_W-1:0] nextAddr;
  cycKind_t          nextKind;

  assign offsetBits = accAddr & ~rangeMask;
  assign memAddr    = offsetBits | (remapBase & rangeMask);
  assign cfgAddr    = cfgWord & FIELD_MASK;

  always_comb begin
    nextKind = CYC_NONE;
    nextAddr = '0;
    if (strobe.selMem) begin
      nextKind = CYC_MEM;
      nextAddr = memAddr;
    end else if (strobe.selCfg) begin
      nextKind = CYC_CFG;
      nextAddr = cfgAddr;
    end else if (strobe.selIo) begin
      nextKind = CYC_IO;
      nextAddr = offsetBits;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outHit  <= 1'b0;
      outKind <= CYC_NONE;
      outAddr <= '0;
    end else begin
      outHit  <= (nextKind != CYC_NONE);
      outKind <= nextKind;
      outAddr <= nextAddr;
    end
  end
endmodule

// File: rtl/winxlate_top.sv
module winxlate_top
  import winxlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 3,
  parameter int BUS_W  = 8,
  parameter int DEV_W  = 5,
  parameter int FN_W   = 3,
  parameter int REG_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWe,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [ADDR_W-1:0] regWdata,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  output logic              outHit,
  output logic [1:0]        outType,
  output logic [ADDR_W-1:0] outAddr
);
  logic [ADDR_W-1:0] rangeMask;
  logic [ADDR_W-1:0] remapBase;
  logic [ADDR_W-1:0] cfgWord;
  logic              cfgEnable;
  xlStrobe_t         strobe;
  cycKind_t          dpKind;

  winxlate_ctrl #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst(rst), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .accValid(accValid), .accAddr(accAddr),
    .rangeMask(rangeMask), .remapBase(remapBase), .cfgWord(cfgWord),
    .cfgEnable(cfgEnable), .strobe(strobe)
  );

  winxlate_dp #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .REG_W(REG_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .accAddr(accAddr),
    .rangeMask(rangeMask), .remapBase(remapBase), .cfgWord(cfgWord),
    .outHit(outHit), .outKind(dpKind), .outAddr(outAddr)
  );

  assign outType = dpKind;
endmodule

// File: rtl/winxlate_chk.sv
module winxlate_chk
  import winxlate_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              accValid,
  input logic [ADDR_W-1:0] accAddr,
  input logic              outHit,
  input logic [1:0]        outType,
  input logic [ADDR_W-1:0] outAddr,
  input logic [ADDR_W-1:0] rangeMask,
  input logic              cfgEnable
);
  AST_HIT_MATCHES_KIND: assert property (@(posedge clk) disable iff (rst)
    outHit == (outType != CYC_NONE));  // R7

  AST_MISS_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
    !outHit |-> (outAddr == '0));  // R7

  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    !accValid |=> !outHit);  // R7

  AST_MEM_KEEPS_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (outType == CYC_MEM) |->
      ((outAddr & ~$past(rangeMask)) == ($past(accAddr) & ~$past(rangeMask))));  // R3

  AST_IO_OFFSET_ONLY: assert property (@(posedge clk) disable iff (rst)
    (outType == CYC_IO) |-> (outAddr == ($past(accAddr) & ~$past(rangeMask))));  // R4

  AST_IO_NEEDS_CFG_OFF: assert property (@(posedge clk) disable iff (rst)
    (outType == CYC_IO) |-> !$past(cfgEnable));  // R4

  AST_CFG_NEEDS_CFG_ON: assert property (@(posedge clk) disable iff (rst)
    (outType == CYC_CFG) |-> $past(cfgEnable));  // R5
endmodule

bind winxlate_top winxlate_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/winxlate_top_tb.sv
`timescale 1ns/1ps
module winxlate_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWe = 1'b0;
  logic [2:0]  regSel = '0;
  logic [31:0] regWdata = '0;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic        outHit;
  logic [1:0]  outType;
  logic [31:0] outAddr;

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";
  bit    done = 1'b0;
  bit    armed = 1'b0;

  always #4 clk = ~clk;

  winxlate_top u_dut (
    .clk(clk), .rst(rst), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .accValid(accValid), .accAddr(accAddr),
    .outHit(outHit), .outType(outType), .outAddr(outAddr)
  );

  // Behavioural reference model
  logic [31:0] mReg [6];
  logic        expHit;
  logic [1:0]  expType;
  logic [31:0] expAddr;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 6; i++) mReg[i] = 32'h0;
      expHit = 0; expType = 0; expAddr = 0;
    end else begin
      logic [31:0] mk;
      bit memOk, ioOk;
      mk    = mReg[0];
      memOk = mReg[5][0] && ((accAddr & mk) == (mReg[1] & mk));
      ioOk  = mReg[5][1] && ((accAddr & mk) == (mReg[2] & mk));
      expHit = 0; expType = 0; expAddr = 0;
      if (accValid && memOk) begin
        expHit = 1; expType = 2'd1;
        expAddr = (accAddr & ~mk) | (mReg[3] & mk);
      end else if (accValid && ioOk) begin
        expHit = 1;
        if (mReg[4][31]) begin
          expType = 2'd3; expAddr = mReg[4] & 32'h00FF_FFFC;
        end else begin
          expType = 2'd2; expAddr = accAddr & ~mk;
        end
      end
      if (regWe && regSel < 3'd6) mReg[regSel] = regWdata;
    end
    armed = 1'b1;
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      checks++;
      if (outHit !== expHit || outType !== expType || outAddr !== expAddr) begin
        errors++;
        $display("FAIL %s: hit/type/addr actual %0b/%0d/%h expected %0b/%0d/%h",
                 curReq, outHit, outType, outAddr, expHit, expType, expAddr);
      end
    end
  end

  task automatic cyc(input bit we, input logic [2:0] sel, input logic [31:0] d,
                     input bit v, input logic [31:0] a);
    @(negedge clk);
    regWe = we; regSel = sel; regWdata = d; accValid = v; accAddr = a;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    cyc(1'b1, sel, d, 1'b0, 32'h0);
  endtask

  task automatic acc(input logic [31:0] a);
    cyc(1'b0, 3'd0, 32'h0, 1'b1, a);
  endtask

  task automatic idle();
    cyc(1'b0, 3'd0, 32'h0, 1'b0, 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    curReq = "R1";
    repeat (3) idle();
    @(negedge clk); rst = 1'b0;
    acc(32'h8000_0000); acc(32'h0000_0000); idle();

    curReq = "R2";
    wr(0, 32'hFFFF_0000); wr(1, 32'h8000_0000); wr(3, 32'h1234_0000); wr(5, 32'h1);
    acc(32'h8000_1234);
    curReq = "R3";
    acc(32'h8000_ABCD); acc(32'h8000_FFFC);

    curReq = "R8";
    wr(0, 32'hFFF0_0000);
    acc(32'h800A_5678); acc(32'h8010_0000);

    curReq = "R4";
    wr(2, 32'h9000_0000); wr(5, 32'h3);
    acc(32'h9000_00AC); acc(32'h900F_FFF0);

    curReq = "R5";
    wr(4, 32'h8000_0000 | (32'd3 << 16) | (32'd5 << 11) | (32'd2 << 8) | (32'd16 << 2) | 32'h3);
    acc(32'h9000_0004); acc(32'h9001_0000);
    wr(4, 32'h0);

    curReq = "R6";
    wr(2, 32'h8000_0000);
    acc(32'h8000_0010);
    wr(2, 32'h9000_0000);

    curReq = "R10";
    wr(5, 32'h2);
    acc(32'h8000_0010); acc(32'h9000_0010);
    wr(5, 32'h1);
    acc(32'h9000_0010);
    wr(5, 32'h3);

    curReq = "R9";
    cyc(1'b1, 3'd1, 32'hA000_0000, 1'b1, 32'h8000_0020);
    acc(32'h8000_0020); acc(32'hA000_0020);

    curReq = "R11";
    wr(6, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF);
    acc(32'hA000_0040); acc(32'h9000_0040);

    curReq = "R7";
    cyc(1'b0, 3'd0, 32'h0, 1'b0, 32'hA000_0000);
    acc(32'h5555_0000); idle();

    curReq = "R8";
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[27:25] == 3'd0) wr(4, {lfsr[31], 31'h0012_3456});
      else if (lfsr[27:25] == 3'd1) acc(lfsr);
      else acc((lfsr[24] ? 32'hA000_0000 : 32'h9000_0000) ^ (lfsr & 32'h003F_FFFF));
    end
    idle(); idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule